// File: doc/BRIEF.md
# Adaptive Flash Page Refresh Scheduler

This block paces the periodic correct-and-refresh work of a flash controller so that retention errors never pile up past what the error-correcting code can repair. A tick counter measures elapsed time. When the refresh period runs out, the block visits every page of its region in ascending order. For each page it asks the flash command layer to read the page. It then waits for the ECC verdict, which carries an error count and an uncorrectable flag. Finally it issues one rewrite command: either a copy to a fresh physical page (remap) or an in-place reprogram.

The period is not fixed. It shrinks as the region wears, based on the program/erase cycle count supplied on an input. A mode input picks the rewrite action. Remap avoids program disturb but costs a later erase. Reprogram avoids the erase but adds program errors, so the hybrid mode only reprograms pages whose error count is still low. A page whose data cannot be corrected is left untouched, and a sticky failure flag is raised.

Top module: `flash_refresh_sched`

## Requirements
- R1: After reset no command is offered (`cmdValid` low), `failFlag` is low, the tick count is zero and the page index is zero.
- R2: The period in ticks is chosen from `peCount` against the ascending thresholds T1<T2<T3<T4: below T1 the one-year step, below T2 the three-month step, below T3 the three-week step, below T4 the three-day step, otherwise the one-day step. Expiry occurs on the tick that completes the period. The command is offered in the cycle after that tick, and the tick count then restarts from zero.
- R3: Each expiry starts one pass that covers pages 0 to PAGES-1 in ascending order. After the last page the index wraps to 0 and the block goes idle until the next expiry.
- R4: For every page, the first command is a read (`cmdOp`=0) of that page. After a correctable ECC result, exactly one rewrite of the same page follows: remap is `cmdOp`=1 and reprogram is `cmdOp`=2.
- R5: `mode`=0 always remaps and `mode`=1 always reprograms in place. `mode` sampled with the ECC result picks the action.
- R6: `mode`=2 or 3 (hybrid) reprograms when `eccErrs` < `errThresh` and remaps when `eccErrs` >= `errThresh`.
- R7: An ECC result with `eccFail`=1 sets `failFlag`, which stays set until reset. No rewrite is issued for that page, and the next command is the read of the following page.
- R8: A command is offered with valid/ready. While `cmdValid` is high and `cmdReady` low, the opcode and page stay unchanged. A new command is never offered before the previous one has its response (`eccValid` for a read, `cmdDone` for a rewrite).
- R9: An expiry that occurs while a pass is in progress is remembered, and one further pass starts right after the current pass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| peCount | input | PE_W | Program/erase cycles endured by the region |
| mode | input | 2 | Rewrite policy: 0 remap, 1 reprogram, 2/3 hybrid |
| errThresh | input | ERR_W | Hybrid threshold on the ECC error count |
| cmdValid | output | 1 | Command offered |
| cmdReady | input | 1 | Command layer accepts the offered command |
| cmdOp | output | 2 | 0 read, 1 remap, 2 reprogram |
| cmdPage | output | PAGE_W | Page addressed by the command |
| eccValid | input | 1 | ECC result for the outstanding read |
| eccErrs | input | ERR_W | Number of bits corrected |
| eccFail | input | 1 | Page was uncorrectable |
| cmdDone | input | 1 | Outstanding rewrite finished |
| failFlag | output | 1 | Sticky uncorrectable-page indication |

## Verification
The hardest situation to reach is a period expiry that lands while a pass is still in progress, because in normal use the period far exceeds the pass time. The bench shortens every period step through parameters. It delivers extra ticks in the middle of a pass, then checks that a second pass starting at page 0 follows immediately after the first. The hybrid decision boundary is driven with error counts of exactly the threshold and one below it. An uncorrectable result is placed in the middle of a pass, to show that the rewrite is skipped and that the flag survives later clean passes.

// File: rtl/flash_refresh_pkg.sv
package flash_refresh_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_REMAP  = 2'd1,
    OP_REPROG = 2'd2
  } refOp_t;

  typedef struct packed {
    logic advPage;
    logic latchEcc;
  } refStrobe_t;
endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import flash_refresh_pkg::*;
#(
  parameter int PAGES  = 1024,
  parameter int PAGE_W = 10,
  parameter int TICK_W = 16,
  parameter int PE_W   = 16,
  parameter int ERR_W  = 8,
  parameter int PE_T1  = 1000,
  parameter int PE_T2  = 2000,
  parameter int PE_T3  = 3000,
  parameter int PE_T4  = 4000,
  parameter int T_YEAR = 8760,
  parameter int T_3MO  = 2190,
  parameter int T_3WK  = 504,
  parameter int T_3DAY = 72,
  parameter int T_DAY  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [PE_W-1:0]   peCount,
  input  logic [1:0]        mode,
  input  logic [ERR_W-1:0]  errThresh,
  input  logic [ERR_W-1:0]  eccErrs,
  input  refStrobe_t        strobe,
  output logic              expire,
  output logic              lastPage,
  output logic [PAGE_W-1:0] pageIdx,
  output refOp_t            wrOp
);
  localparam logic [PAGE_W-1:0] LAST_IDX = PAGE_W'(PAGES - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] periodTicks;
  refOp_t            pickOp;

  // wear-based period step
  always_comb begin
    if (peCount < PE_W'(PE_T1))      periodTicks = TICK_W'(T_YEAR);
    else if (peCount < PE_W'(PE_T2)) periodTicks = TICK_W'(T_3MO);
    else if (peCount < PE_W'(PE_T3)) periodTicks = TICK_W'(T_3WK);
    else if (peCount < PE_W'(PE_T4)) periodTicks = TICK_W'(T_3DAY);
    else                             periodTicks = TICK_W'(T_DAY);
  end

  assign expire = tick && (tickCnt >= periodTicks - TICK_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)       tickCnt <= '0;
    else if (expire) tickCnt <= '0;
    else if (tick)   tickCnt <= tickCnt + TICK_W'(1);
  end

  assign lastPage = (pageIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN)               pageIdx <= '0;
    else if (strobe.advPage) pageIdx <= lastPage ? '0 : pageIdx + PAGE_W'(1);
  end

  // rewrite action policy
  always_comb begin
    case (mode)
      2'd0:    pickOp = OP_REMAP;
      2'd1:    pickOp = OP_REPROG;
      default: pickOp = (eccErrs < errThresh) ? OP_REPROG : OP_REMAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                wrOp <= OP_REMAP;
    else if (strobe.latchEcc) wrOp <= pickOp;
  end
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import flash_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       expire,
  input  logic       lastPage,
  input  refOp_t     wrOp,
  input  logic       cmdReady,
  input  logic       eccValid,
  input  logic       eccFail,
  input  logic       cmdDone,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic       failFlag,
  output refStrobe_t strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_WAIT_ECC, S_WR_REQ, S_WAIT_DONE, S_NEXT
  } state_t;

  state_t state;
  state_t nextState;
  logic   pendStart;

  always_comb begin
    nextState      = state;
    strobe.advPage  = 1'b0;
    strobe.latchEcc = 1'b0;
    case (state)
      S_IDLE:      if (expire || pendStart) nextState = S_RD_REQ;
      S_RD_REQ:    if (cmdReady) nextState = S_WAIT_ECC;
      S_WAIT_ECC:
        if (eccValid) begin
          strobe.latchEcc = 1'b1;
          nextState       = eccFail ? S_NEXT : S_WR_REQ;
        end
      S_WR_REQ:    if (cmdReady) nextState = S_WAIT_DONE;
      S_WAIT_DONE: if (cmdDone) nextState = S_NEXT;
      S_NEXT: begin
        strobe.advPage = 1'b1;
        nextState      = lastPage ? S_IDLE : S_RD_REQ;
      end
      default:     nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pendStart <= 1'b0;
      failFlag  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE) pendStart <= 1'b0;
      else if (expire)     pendStart <= 1'b1;
      if (state == S_WAIT_ECC && eccValid && eccFail) failFlag <= 1'b1;
    end
  end

  assign cmdValid = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign cmdOp    = (state == S_WR_REQ) ? wrOp : OP_READ;
endmodule

// File: rtl/flash_refresh_sched.sv
module flash_refresh_sched
  import flash_refresh_pkg::*;
#(
  parameter int PAGES  = 1024,
  parameter int TICK_W = 16,
  parameter int PE_W   = 16,
  parameter int ERR_W  = 8,
  parameter int PE_T1  = 1000,
  parameter int PE_T2  = 2000,
  parameter int PE_T3  = 3000,
  parameter int PE_T4  = 4000,
  parameter int T_YEAR = 8760,
  parameter int T_3MO  = 2190,
  parameter int T_3WK  = 504,
  parameter int T_3DAY = 72,
  parameter int T_DAY  = 24,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [PE_W-1:0]   peCount,
  input  logic [1:0]        mode,
  input  logic [ERR_W-1:0]  errThresh,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [1:0]        cmdOp,
  output logic [PAGE_W-1:0] cmdPage,
  input  logic              eccValid,
  input  logic [ERR_W-1:0]  eccErrs,
  input  logic              eccFail,
  input  logic              cmdDone,
  output logic              failFlag
);
  refStrobe_t strobe;
  logic       expire;
  logic       lastPage;
  refOp_t     wrOp;

  refresh_dp #(
    .PAGES(PAGES), .PAGE_W(PAGE_W), .TICK_W(TICK_W), .PE_W(PE_W), .ERR_W(ERR_W),
    .PE_T1(PE_T1), .PE_T2(PE_T2), .PE_T3(PE_T3), .PE_T4(PE_T4),
    .T_YEAR(T_YEAR), .T_3MO(T_3MO), .T_3WK(T_3WK), .T_3DAY(T_3DAY), .T_DAY(T_DAY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .peCount(peCount), .mode(mode),
    .errThresh(errThresh), .eccErrs(eccErrs), .strobe(strobe),
    .expire(expire), .lastPage(lastPage), .pageIdx(cmdPage), .wrOp(wrOp)
  );

  refresh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .expire(expire), .lastPage(lastPage), .wrOp(wrOp),
    .cmdReady(cmdReady), .eccValid(eccValid), .eccFail(eccFail), .cmdDone(cmdDone),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .failFlag(failFlag), .strobe(strobe)
  );
endmodule

// File: rtl/flash_refresh_sched_chk.sv
module flash_refresh_sched_chk #(
  parameter int PAGES  = 1024,
  parameter int PAGE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdOp,
  input logic [PAGE_W-1:0] cmdPage,
  input logic              eccValid,
  input logic              eccFail,
  input logic              cmdDone,
  input logic              failFlag
);
  logic outst;

  always_ff @(posedge clk) begin
    if (!rstN)                     outst <= 1'b0;
    else if (cmdValid && cmdReady) outst <= 1'b1;
    else if (eccValid || cmdDone)  outst <= 1'b0;
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdPage));

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !outst);

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> failFlag);

  a_r7_fail_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> $past(eccValid && eccFail));

  a_r3_page_range: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (32'(cmdPage) < PAGES));

  a_r4_legal_op: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdOp != 2'd3));
endmodule

bind flash_refresh_sched flash_refresh_sched_chk #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
  .cmdPage(cmdPage), .eccValid(eccValid), .eccFail(eccFail), .cmdDone(cmdDone),
  .failFlag(failFlag)
);

// File: tb/flash_refresh_sched_bench.sv
`timescale 1ns/1ps
module flash_refresh_sched_bench;
  localparam int PAGES = 4;
  localparam int PW    = 2;
  localparam int EW    = 8;
  localparam int PEW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [PEW-1:0] peCount = '0;
  logic [1:0] mode = 2'd0;
  logic [EW-1:0] errThresh = 8'd5;
  logic cmdValid, cmdReady = 1'b0;
  logic [1:0] cmdOp;
  logic [PW-1:0] cmdPage;
  logic eccValid = 1'b0, eccFail = 1'b0, cmdDone = 1'b0;
  logic [EW-1:0] eccErrs = '0;
  logic failFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  flash_refresh_sched #(
    .PAGES(PAGES), .TICK_W(8), .PE_W(PEW), .ERR_W(EW),
    .PE_T1(100), .PE_T2(200), .PE_T3(300), .PE_T4(400),
    .T_YEAR(11), .T_3MO(9), .T_3WK(7), .T_3DAY(5), .T_DAY(3)
  ) u_flash_refresh_sched (
    .clk(clk), .rstN(rstN), .tick(tick), .peCount(peCount), .mode(mode),
    .errThresh(errThresh), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdPage(cmdPage), .eccValid(eccValid), .eccErrs(eccErrs), .eccFail(eccFail),
    .cmdDone(cmdDone), .failFlag(failFlag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse_tick();
  endtask

  // waits for an offered command, checks it and accepts it
  task automatic take_cmd(input int expOp, input int expPage, input string tag);
    int w = 0;
    while (!cmdValid && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk(cmdValid, {tag, " valid"}, cmdValid, 1);
    chk(cmdOp == expOp, {tag, " op"}, cmdOp, expOp);
    chk(cmdPage == expPage, {tag, " page"}, cmdPage, expPage);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic ecc_rsp(input int errs, input bit fl);
    @(negedge clk);
    eccErrs = EW'(errs);
    eccFail = fl;
    eccValid = 1'b1;
    @(negedge clk);
    eccValid = 1'b0;
    eccFail = 1'b0;
  endtask

  task automatic done_rsp();
    @(negedge clk);
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  task automatic do_page(input int pg, input int errs, input int expOp, input string tag);
    take_cmd(0, pg, {tag, " read"});
    ecc_rsp(errs, 1'b0);
    take_cmd(expOp, pg, {tag, " rewrite"});
    done_rsp();
  endtask

  task automatic do_pass(input int expOp, input string tag);
    for (int p = 0; p < PAGES; p++) do_page(p, 1, expOp, tag);
  endtask

  task automatic expect_idle(input string tag);
    repeat (5) @(negedge clk);
    chk(!cmdValid, tag, cmdValid, 0);
  endtask

  // checks the period at the current wear level; the pass is then started
  task automatic period_check(input int per, input string tag);
    ticks(per - 1);
    chk(!cmdValid, {tag, " before expiry"}, cmdValid, 0);
    pulse_tick();
    chk(cmdValid, {tag, " at expiry"}, cmdValid, 1);
  endtask

  task automatic t_reset();
    chk(!cmdValid, "R1 reset cmdValid", cmdValid, 0);
    chk(!failFlag, "R1 reset failFlag", failFlag, 0);
  endtask

  task automatic t_low_wear_remap();
    peCount = 16'd0;
    mode = 2'd0;
    period_check(11, "R2 year step");
    do_pass(1, "R3 R4 R5 remap pass");
    expect_idle("R3 idle after pass");
  endtask

  task automatic t_reprog_mode();
    peCount = 16'd150;
    mode = 2'd1;
    period_check(9, "R2 3-month step");
    do_pass(2, "R5 reprogram pass");
    expect_idle("R3 idle after reprogram pass");
  endtask

  task automatic t_hybrid();
    peCount = 16'd250;
    mode = 2'd2;
    errThresh = 8'd5;
    period_check(7, "R2 3-week step");
    do_page(0, 4, 2, "R6 below threshold");
    do_page(1, 5, 1, "R6 at threshold");
    mode = 2'd3;
    do_page(2, 0, 2, "R6 mode3 zero errors");
    do_page(3, 200, 1, "R6 mode3 many errors");
    expect_idle("R3 idle after hybrid pass");
  endtask

  task automatic t_stall();
    peCount = 16'd350;
    mode = 2'd0;
    period_check(5, "R2 3-day step");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmdValid && cmdPage == 0 && cmdOp == 0, "R8 held while not ready", cmdValid, 1);
    end
    take_cmd(0, 0, "R8 stalled read");
    // no new command while the read is outstanding
    repeat (3) @(negedge clk);
    chk(!cmdValid, "R8 nothing while outstanding", cmdValid, 0);
    ecc_rsp(1, 1'b0);
    take_cmd(1, 0, "R8 rewrite after stall");
    done_rsp();
    for (int p = 1; p < PAGES; p++) do_page(p, 1, 1, "R8 rest of pass");
    expect_idle("R3 idle after stall pass");
  endtask

  task automatic t_uncorrectable();
    peCount = 16'd500;
    mode = 2'd0;
    period_check(3, "R2 1-day step");
    do_page(0, 1, 1, "R7 clean page");
    take_cmd(0, 1, "R7 read of failing page");
    ecc_rsp(0, 1'b1);
    @(negedge clk);
    chk(failFlag, "R7 flag set", failFlag, 1);
    take_cmd(0, 2, "R7 next read, no rewrite");
    ecc_rsp(1, 1'b0);
    take_cmd(1, 2, "R7 rewrite next page");
    done_rsp();
    do_page(3, 1, 1, "R7 last page");
    expect_idle("R3 idle after fail pass");
    period_check(3, "R2 1-day again");
    do_pass(1, "R7 clean pass");
    chk(failFlag, "R7 flag sticky", failFlag, 1);
  endtask

  task automatic t_pending();
    peCount = 16'd500;
    mode = 2'd1;
    period_check(3, "R9 first expiry");
    do_page(0, 1, 2, "R9 first pass");
    ticks(3);
    for (int p = 1; p < PAGES; p++) do_page(p, 1, 2, "R9 first pass");
    @(negedge clk);
    @(negedge clk);
    chk(cmdValid && cmdPage == 0, "R9 second pass starts at page 0", cmdPage, 0);
    do_pass(2, "R9 second pass");
    expect_idle("R9 only one extra pass");
  endtask

  initial begin
    fork
      begin
        while (cycles < 100000) begin
          @(posedge clk);
          cycles++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_wear_remap();
        t_reprog_mode();
        t_hybrid();
        t_stall();
        t_uncorrectable();
        t_pending();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join
  end
endmodule